// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block watches the byte stream of an incoming Ethernet frame, collects the six bytes of the destination address that open the frame, and decides whether the frame is wanted. A frame is wanted when promiscuous operation is on, when it is a broadcast and broadcasts are allowed, when a unicast address equals the programmed station address, or when a hash of the address selects a set bit in the unicast or the multicast table. Each decision comes with a reason code, so the logic downstream can tell which rule let the frame in.

The hash is computed on the fly while the address bytes stream in. It uses the usual Ethernet CRC-32 (polynomial 0x04C11DB7, register preset to all ones, each byte fed least significant bit first). The top six bits of the register after the sixth byte pick one of 64 table bits. All configuration is captured together with the start-of-frame byte, so software may rewrite it at any time without corrupting a frame that is in flight.

Top module: `rxaf_top`

## Requirements
- R1: After reset, and in any cycle without a decision, `dec_valid`, `dec_accept` and `dec_reason` are all 0.
- R2: A byte is taken when `in_valid` is 1. The byte taken with `in_sof`=1 is destination byte 0, and the following five taken bytes complete the address. `dec_valid` is 1 for exactly one cycle, the cycle right after the clock edge that takes the sixth byte.
- R3: When promiscuous mode is on, every complete address is accepted with reason 1 (promiscuous), including a rejected broadcast.
- R4: An all-ones destination yields reason 2 (broadcast, accepted) when `bcast_reject`=0 and reason 0 (rejected) when `bcast_reject`=1.
- R5: A unicast destination (bit 0 of byte 0 is 0) that equals `station_addr` yields reason 3 (exact). Byte k of the address maps to `station_addr[8k+7:8k]`. Any differing bit means no exact match.
- R6: A unicast destination that is not an exact match yields reason 4 (unicast hash) when `uc_hash[idx]` is 1 and reason 0 otherwise. Here idx is bits 31..26 of the CRC register described above, taken after byte 5.
- R7: A destination whose byte 0 has bit 0 set, other than broadcast, yields reason 5 (multicast hash) when `mc_hash[idx]` is 1 and reason 0 otherwise. `uc_hash` and `station_addr` have no effect on it. Broadcast is judged before the multicast table.
- R8: A start-of-frame byte that arrives before six bytes are collected restarts collection, so the aborted short frame produces no decision.
- R9: Station address, table and mode inputs are captured on the start-of-frame byte. Changes during the rest of the frame do not alter that frame's decision.
- R10: Bytes taken before the first start-of-frame after reset, and bytes after the sixth byte of a frame, produce no decision.
- R11: `dec_accept` is 1 exactly when `dec_valid` is 1 and `dec_reason` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Receive byte present this cycle |
| in_sof | input | 1 | Marks the first byte of a frame |
| in_byte | input | 8 | Receive byte |
| station_addr | input | 48 | Station address, byte 0 in bits 7:0 |
| bcast_reject | input | 1 | 1 rejects broadcast frames |
| promisc | input | 1 | 1 accepts every frame |
| uc_hash | input | 64 | Unicast hash table |
| mc_hash | input | 64 | Multicast hash table |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | Frame accepted |
| dec_reason | output | 3 | 0 reject, 1 promiscuous, 2 broadcast, 3 exact, 4 unicast hash, 5 multicast hash |

## Verification
The bench derives the hash index from its own bit-serial CRC. It then sets only that table bit, or every bit except that one, so a wrong bit order, the wrong CRC bits or a swapped table would flip the verdict. A broadcast address is sent while every multicast bit is set and broadcasts are rejected. A design that tested the multicast table first would accept that frame. An aborted three-byte frame followed by a full one must give a single strobe, which catches a counter that does not restart. A mode and station change in the middle of a frame must leave the verdict alone, which catches configuration that is read live. Stray bytes before the first frame start and after the sixth byte must give no strobe.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

    localparam int ADDR_BYTES = 6;
    localparam int ADDR_W     = ADDR_BYTES * 8;
    localparam int HASH_BITS  = 6;
    localparam int HASH_SIZE  = 1 << HASH_BITS;
    localparam int CRC_W      = 32;
    localparam int CNT_W      = $clog2(ADDR_BYTES + 1);
    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;
    localparam logic [CRC_W-1:0] CRC_INIT = '1;

    typedef enum logic [2:0] {
        RSN_REJECT  = 3'd0,
        RSN_PROMISC = 3'd1,
        RSN_BCAST   = 3'd2,
        RSN_EXACT   = 3'd3,
        RSN_UHASH   = 3'd4,
        RSN_MHASH   = 3'd5
    } rsn_e;

    typedef struct packed {
        logic [ADDR_W-1:0]    station;
        logic                 bcast_reject;
        logic                 promisc;
        logic [HASH_SIZE-1:0] uc_hash;
        logic [HASH_SIZE-1:0] mc_hash;
    } filt_cfg_t;

    typedef struct packed {
        logic valid;
        logic accept;
        rsn_e reason;
    } filt_dec_t;

    // One byte of the serial CRC, data bit 0 enters first.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic [7:0] d);
        logic [CRC_W-1:0] r;
        logic fb;
        r = c;
        for (int i = 0; i < 8; i++) begin
            fb = r[CRC_W-1] ^ d[i];
            r  = {r[CRC_W-2:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

endpackage

// File: rtl/rxaf_collect.sv
module rxaf_collect
    import rxaf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic                 in_sof,
    input  logic [7:0]           in_byte,
    output logic [ADDR_W-1:0]    addr,
    output logic [HASH_BITS-1:0] hidx,
    output logic                 done
);
    logic [CNT_W-1:0] cnt;
    logic             armed;
    logic [CRC_W-1:0] crc;
    logic             take_sof;
    logic             take_more;

    assign take_sof  = in_valid && in_sof;
    assign take_more = in_valid && !in_sof && armed && (cnt < CNT_W'(ADDR_BYTES));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            armed <= 1'b0;
            crc   <= CRC_INIT;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (take_sof) begin
                cnt   <= CNT_W'(1);
                armed <= 1'b1;
                crc   <= crc_step(CRC_INIT, in_byte);
            end else if (take_more) begin
                cnt <= cnt + CNT_W'(1);
                crc <= crc_step(crc, in_byte);
                if (cnt == CNT_W'(ADDR_BYTES - 1)) done <= 1'b1;
            end
        end
    end

    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                addr[8*g +: 8] <= '0;
            end else if ((take_sof && g == 0) ||
                         (take_more && cnt == CNT_W'(g))) begin
                addr[8*g +: 8] <= in_byte;
            end
        end
    end

    assign hidx = crc[CRC_W-1 -: HASH_BITS];

    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(ADDR_BYTES));
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_sof_no_done_R8: assert property (@(posedge clk) disable iff (rst)
        take_sof |=> !done);
    assert_idle_no_done_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !done);
endmodule

// File: rtl/rxaf_cfg_snap.sv
module rxaf_cfg_snap
    import rxaf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      capture,
    input  filt_cfg_t cfg_in,
    output filt_cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst)          cfg_q <= '0;
        else if (capture) cfg_q <= cfg_in;
    end

    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(cfg_q));
endmodule

// File: rtl/rxaf_decide.sv
module rxaf_decide
    import rxaf_pkg::*;
(
    input  logic [ADDR_W-1:0]    addr,
    input  logic [HASH_BITS-1:0] hidx,
    input  logic                 done,
    input  filt_cfg_t            cfg,
    output filt_dec_t            dec
);
    logic is_bcast;
    logic is_mcast;
    rsn_e rsn;

    assign is_bcast = &addr;
    assign is_mcast = addr[0];

    always_comb begin
        if (cfg.promisc)            rsn = RSN_PROMISC;
        else if (is_bcast)          rsn = cfg.bcast_reject ? RSN_REJECT : RSN_BCAST;
        else if (is_mcast)          rsn = cfg.mc_hash[hidx] ? RSN_MHASH : RSN_REJECT;
        else if (addr == cfg.station) rsn = RSN_EXACT;
        else if (cfg.uc_hash[hidx]) rsn = RSN_UHASH;
        else                        rsn = RSN_REJECT;
    end

    always_comb begin
        dec.valid  = done;
        dec.reason = done ? rsn : RSN_REJECT;
        dec.accept = done && (rsn != RSN_REJECT);
    end

    always_comb begin
        if (done && is_mcast && !cfg.promisc)
            assert_mc_path_R7: assert (rsn != RSN_EXACT && rsn != RSN_UHASH);
    end
endmodule

// File: rtl/rxaf_top.sv
module rxaf_top
    import rxaf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic        in_sof,
    input  logic [7:0]  in_byte,
    input  logic [47:0] station_addr,
    input  logic        bcast_reject,
    input  logic        promisc,
    input  logic [63:0] uc_hash,
    input  logic [63:0] mc_hash,
    output logic        dec_valid,
    output logic        dec_accept,
    output logic [2:0]  dec_reason
);
    filt_cfg_t            cfg_live;
    filt_cfg_t            cfg_snap;
    logic [ADDR_W-1:0]    addr;
    logic [HASH_BITS-1:0] hidx;
    logic                 done;
    filt_dec_t            dec;

    always_comb begin
        cfg_live.station      = station_addr;
        cfg_live.bcast_reject = bcast_reject;
        cfg_live.promisc      = promisc;
        cfg_live.uc_hash      = uc_hash;
        cfg_live.mc_hash      = mc_hash;
    end

    rxaf_collect u_collect (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .in_byte  (in_byte),
        .addr     (addr),
        .hidx     (hidx),
        .done     (done)
    );

    rxaf_cfg_snap u_snap (
        .clk     (clk),
        .rst     (rst),
        .capture (in_valid && in_sof),
        .cfg_in  (cfg_live),
        .cfg_q   (cfg_snap)
    );

    rxaf_decide u_decide (
        .addr (addr),
        .hidx (hidx),
        .done (done),
        .cfg  (cfg_snap),
        .dec  (dec)
    );

    assign dec_valid  = dec.valid;
    assign dec_accept = dec.accept;
    assign dec_reason = dec.reason;

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |-> (!dec_accept && dec_reason == 3'd0));
    assert_accept_code_R11: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> (dec_accept == (dec_reason != 3'd0)));
    assert_promisc_R3: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && cfg_snap.promisc) |-> dec_accept);
    assert_bcast_policy_R4: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !cfg_snap.promisc && (&addr)) |-> (dec_accept == !cfg_snap.bcast_reject));
    assert_exact_R5: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !cfg_snap.promisc && !addr[0] && addr == cfg_snap.station)
            |-> dec_reason == 3'd3);
endmodule

// File: tb/tb_rxaf_top.sv
module tb_rxaf_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] C_REJ = 3'd0, C_PRO = 3'd1, C_BC = 3'd2,
                           C_EX = 3'd3, C_UH = 3'd4, C_MH = 3'd5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_sof = 1'b0;
    logic [7:0]  in_byte = '0;
    logic [47:0] station_addr = '0;
    logic        bcast_reject = 1'b0;
    logic        promisc = 1'b0;
    logic [63:0] uc_hash = '0;
    logic [63:0] mc_hash = '0;
    logic        dec_valid;
    logic        dec_accept;
    logic [2:0]  dec_reason;

    int n_cmp = 0;
    int n_bad = 0;
    int pulses = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxaf_top dut (.*);

    always @(negedge clk) if (!rst && dec_valid) pulses++;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Bit-serial CRC over the 48 address bits, byte 0 first, bit 0 first.
    function automatic logic [5:0] ref_idx(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int k = 0; k < 48; k++) begin
            logic top = c[31];
            c = c << 1;
            if (top != a[k]) c = c ^ 32'h04C11DB7;
        end
        return c[31:26];
    endfunction

    task automatic put(input logic [7:0] b, input logic s);
        @(negedge clk);
        in_valid = 1'b1; in_sof = s; in_byte = b;
    endtask

    task automatic idle;
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0;
    endtask

    // Sends a 6-byte address, then checks strobe, verdict and single-cycle pulse.
    task automatic frame_expect(input string req, input logic [47:0] a, input logic [2:0] exp);
        for (int i = 0; i < 6; i++) put(a[8*i +: 8], i == 0);
        idle;
        chk({req, " strobe"}, dec_valid, 1);
        chk({req, " reason"}, dec_reason, exp);
        chk({req, " accept R11"}, dec_accept, exp != C_REJ);
        @(negedge clk);
        chk({req, " one-cycle R2"}, dec_valid, 0);
    endtask

    task automatic t_reset;
        chk("R1 valid after reset", dec_valid, 0);
        chk("R1 accept after reset", dec_accept, 0);
        chk("R1 reason after reset", dec_reason, 0);
    endtask

    task automatic t_pre_sof;
        int p0 = pulses;
        for (int i = 0; i < 6; i++) put(8'hFF, 1'b0);
        idle; @(negedge clk);
        chk("R10 bytes before first sof", pulses - p0, 0);
    endtask

    task automatic t_bcast;
        bcast_reject = 0; mc_hash = '0;
        frame_expect("R4 broadcast allowed", '1, C_BC);
        bcast_reject = 1; mc_hash = '1;
        frame_expect("R4 R7 broadcast rejected over mc table", '1, C_REJ);
        bcast_reject = 0; mc_hash = '0;
    endtask

    task automatic t_promisc;
        promisc = 1; bcast_reject = 1;
        frame_expect("R3 promisc broadcast", '1, C_PRO);
        frame_expect("R3 promisc unicast", 48'h123456789A02, C_PRO);
        promisc = 0; bcast_reject = 0;
    endtask

    task automatic t_exact;
        station_addr = 48'hA1B2C3D4E5F6 & ~48'h1; uc_hash = '0;
        frame_expect("R5 exact", station_addr, C_EX);
        frame_expect("R5 near miss", station_addr ^ 48'h800000000000, C_REJ);
    endtask

    task automatic t_uhash;
        logic [47:0] a = 48'h665544332210;
        logic [5:0]  ix = ref_idx(a);
        station_addr = 48'h0A0B0C0D0E00;
        uc_hash = 64'd1 << ix; mc_hash = '0;
        frame_expect("R6 unicast hash hit", a, C_UH);
        uc_hash = ~(64'd1 << ix); mc_hash = '1;
        frame_expect("R6 unicast hash miss", a, C_REJ);
        uc_hash = '0; mc_hash = '0;
    endtask

    task automatic t_mhash;
        logic [47:0] a = 48'h0000005E0001;
        logic [5:0]  ix = ref_idx(a);
        mc_hash = 64'd1 << ix; uc_hash = '0;
        frame_expect("R7 multicast hash hit", a, C_MH);
        mc_hash = ~(64'd1 << ix); uc_hash = '1; station_addr = a;
        frame_expect("R7 multicast miss ignores uc table and station", a, C_REJ);
        mc_hash = '0; uc_hash = '0;
    endtask

    task automatic t_short;
        int p0;
        station_addr = 48'h223344556678; uc_hash = '0;
        p0 = pulses;
        put(8'h99, 1'b1); put(8'h98, 1'b0); put(8'h97, 1'b0);
        frame_expect("R8 restart after short frame", station_addr, C_EX);
        chk("R8 single decision", pulses - p0, 1);
    endtask

    task automatic t_trailing;
        int p0 = pulses;
        for (int i = 0; i < 8; i++) put(8'hFF, 1'b0);
        idle; @(negedge clk);
        chk("R10 bytes after sixth byte", pulses - p0, 0);
    endtask

    task automatic t_snapshot;
        logic [47:0] b = 48'h5A5A5A5A5A5A;
        promisc = 0; uc_hash = '0; mc_hash = '0; station_addr = 48'h111111111110;
        put(b[7:0], 1'b1);
        @(negedge clk);
        promisc = 1; station_addr = b; uc_hash = '1;
        in_sof = 1'b0; in_byte = b[15:8];
        for (int i = 2; i < 6; i++) put(b[8*i +: 8], 1'b0);
        idle;
        chk("R9 mid-frame change strobe", dec_valid, 1);
        chk("R9 mid-frame change reason", dec_reason, C_REJ);
        @(negedge clk);
        frame_expect("R9 new config at next sof", b, C_PRO);
        promisc = 0; uc_hash = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_pre_sof;
        t_bcast;
        t_promisc;
        t_exact;
        t_uhash;
        t_mhash;
        t_short;
        t_trailing;
        t_snapshot;
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule